// File: doc/BRIEF.md
# Conditional Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a direct-mapped array of entries. Each entry has a two-bit saturating counter and a flag that records whether the entry has ever been trained. The front end presents a branch address and the branch's signed displacement on the lookup side. In the same cycle it receives a combinational taken/not-taken guess.

When a branch retires, the commit stage drives the update side with that branch's address and its real outcome. The indexed entry is then marked as trained and its counter moves one step toward the outcome. An entry that has never been trained gives no history to go on. In that case the block falls back to a fixed rule: a backward branch (negative displacement) is predicted taken, and a forward one is predicted not taken.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry is untrained, with its counter at 0, so every lookup follows the fixed displacement rule.
- R2: The entry index is address bits [IDX_W:1], where IDX_W = log2(ENTRIES). Address bit 0 and the bits above IDX_W do not affect which entry is selected.
- R3: A lookup that hits a trained entry predicts taken when the counter is 2 or 3, and not taken when it is 0 or 1.
- R4: A lookup that hits an untrained entry predicts taken exactly when the displacement's most significant bit is 1.
- R5: An update marks the indexed entry as trained from the next cycle on.
- R6: An update with outcome taken adds one to the counter, and the counter stays at 3 once it reaches 3.
- R7: An update with outcome not taken subtracts one from the counter, and the counter stays at 0 once it reaches 0.
- R8: In a cycle without an update, no entry changes.
- R9: When a lookup and an update select the same entry in the same cycle, the lookup sees the entry as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_ofs | input | OFS_W | Signed displacement of that branch |
| lk_taken | output | 1 | Prediction: 1 = taken |
| up_en | input | 1 | A committed branch is being reported |
| up_pc | input | PC_W | Address of the committed branch |
| up_taken | input | 1 | Real outcome of the committed branch |

## Verification
The bench builds the block with ENTRIES = 16, PC_W = 32 and OFS_W = 13. With only 16 entries, random addresses drawn from a small pool collide often. This means aliased addresses, repeated training of the same entry and both saturation limits all come up within a few hundred cycles. The 13-bit displacement leaves the sign bit at a clearly separate position, so the fixed rule is checked independently of the counters.

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32,
  parameter int OFS_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [OFS_W-1:0] lk_ofs,
  output logic             lk_taken,
  input  logic             up_en,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]      vld;
  logic [ENTRIES-1:0][1:0] cnt;
  logic [IDX_W-1:0]        lk_idx, up_idx;
  logic                    unused_bits;

  assign lk_idx = lk_pc[IDX_W:1];
  assign up_idx = up_pc[IDX_W:1];
  assign unused_bits = ^{lk_pc[0], up_pc[0], lk_pc[PC_W-1:IDX_W+1],
                         up_pc[PC_W-1:IDX_W+1], lk_ofs[OFS_W-2:0]};

  assign lk_taken = vld[lk_idx] ? cnt[lk_idx][1] : lk_ofs[OFS_W-1];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = up_en && (up_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[e] <= 1'b0;
        cnt[e] <= 2'd0;
      end else if (hit) begin
        vld[e] <= 1'b1;
        if (up_taken && cnt[e] != 2'd3)       cnt[e] <= cnt[e] + 2'd1;
        else if (!up_taken && cnt[e] != 2'd0) cnt[e] <= cnt[e] - 2'd1;
      end
    end
  end
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    up_en,
  input logic [PC_W-1:0]         up_pc,
  input logic                    up_taken,
  input logic [ENTRIES-1:0]      vld,
  input logic [ENTRIES-1:0][1:0] cnt
);
  localparam int IDX_W = $clog2(ENTRIES);
  logic [IDX_W-1:0] ui;
  assign ui = up_pc[IDX_W:1];

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (vld == '0) && (cnt == '0));

  a_r5_trained: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> vld[$past(ui)]);

  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_taken && cnt[ui] != 2'd3 |=> cnt[$past(ui)] == $past(cnt[ui]) + 2'd1);

  a_r6_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_taken && cnt[ui] == 2'd3 |=> cnt[$past(ui)] == 2'd3);

  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !up_taken && cnt[ui] != 2'd0 |=> cnt[$past(ui)] == $past(cnt[ui]) - 2'd1);

  a_r7_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !up_taken && cnt[ui] == 2'd0 |=> cnt[$past(ui)] == 2'd0);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !up_en |=> $stable(vld) && $stable(cnt));
endmodule

bind bht_predictor bht_predictor_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .up_en(up_en), .up_pc(up_pc),
  .up_taken(up_taken), .vld(vld), .cnt(cnt));

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16;
  localparam int PC_W = 32;
  localparam int OFS_W = 13;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic [OFS_W-1:0] lk_ofs = '0;
  logic up_en = 1'b0, up_taken = 1'b0;
  logic lk_taken;

  int checks = 0, fails = 0;
  bit m_vld [ENTRIES];
  int m_cnt [ENTRIES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bht_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W), .OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_ofs(lk_ofs), .lk_taken(lk_taken),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> 1) % ENTRIES);
  endfunction

  function automatic bit expect_pred(logic [PC_W-1:0] pc, logic [OFS_W-1:0] ofs);
    int i = idx_of(pc);
    if (m_vld[i]) return m_cnt[i] >= 2;
    return ofs[OFS_W-1];
  endfunction

  task automatic step(logic [PC_W-1:0] lpc, logic [OFS_W-1:0] lofs,
                      bit ue, logic [PC_W-1:0] upc, bit ut, string req);
    bit exp;
    @(negedge clk);
    lk_pc = lpc; lk_ofs = lofs; up_en = ue; up_pc = upc; up_taken = ut;
    #1;
    exp = expect_pred(lpc, lofs);
    checks++;
    if (lk_taken !== exp) begin
      fails++;
      $display("FAIL %s pc=%h ofs=%h actual=%b expected=%b", req, lpc, lofs, lk_taken, exp);
    end
    @(posedge clk);
    if (ue) begin
      int i = idx_of(upc);
      m_vld[i] = 1'b1;
      if (ut && m_cnt[i] < 3) m_cnt[i]++;
      else if (!ut && m_cnt[i] > 0) m_cnt[i]--;
    end
  endtask

  localparam logic [OFS_W-1:0] NEG = 13'h1ff0;
  localparam logic [OFS_W-1:0] POS = 13'h0010;

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < ENTRIES; i++) begin m_vld[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R4: untrained entries follow displacement sign
    for (int i = 0; i < ENTRIES; i++) begin
      step(32'(i*2), NEG, 0, '0, 0, "R1");
      step(32'(i*2), POS, 0, '0, 0, "R4");
    end
    // R5 / R3: one not-taken update on an entry, backward branch now predicted not taken
    step(32'h100, NEG, 1, 32'h100, 0, "R9");
    step(32'h100, NEG, 0, '0, 0, "R5");
    // R6: train up past the top
    for (int k = 0; k < 5; k++) step(32'h104, POS, 1, 32'h104, 1, "R6");
    step(32'h104, POS, 0, '0, 0, "R3");
    // R7: train down past the bottom
    for (int k = 0; k < 5; k++) step(32'h104, NEG, 1, 32'h104, 0, "R7");
    step(32'h104, NEG, 0, '0, 0, "R7");
    // R2: aliases (bit 0 and high bits) hit the same entry
    step(32'h108, POS, 1, 32'h108, 1, "R2");
    step(32'h108, POS, 1, 32'h108, 1, "R2");
    step(32'h109, POS, 0, '0, 0, "R2");
    step(32'h108 + 32'(2*ENTRIES), POS, 0, '0, 0, "R2");
    step(32'hF000_0108, POS, 0, '0, 0, "R2");
    // R9: same-entry lookup and update at the threshold
    step(32'h10C, POS, 1, 32'h10C, 1, "R9");
    step(32'h10C, POS, 1, 32'h10C, 1, "R9");
    step(32'h10C, POS, 0, '0, 0, "R9");
    // R8: idle cycles leave predictions unchanged
    for (int k = 0; k < 8; k++) step(32'h10C, NEG, 0, 32'h10C, 0, "R8");
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [PC_W-1:0] a = {$urandom} & 32'h0000_007F;
      logic [PC_W-1:0] b = {$urandom} & 32'h0000_007F;
      logic [OFS_W-1:0] o = OFS_W'($urandom);
      step(a, o, ($urandom % 4) != 0, b, $urandom % 2, "R3");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule